// File: doc/BRIEF.md
# Sleep Control Register Decoder

This block holds a 16-bit power-management control word and turns software sleep commands written into it into single-cycle request pulses for the power sequencer. Three requests exist: power-off, suspend-to-RAM and suspend-to-disk (hibernate). A 3-bit sleep-type field in the written word selects the request. A sleep-enable bit in the same word acts as a trigger. It is never kept in the register. Which sleep-type value means hibernate is set by an input, so that the platform can program it.

Bit 0 of the register is the SCI-enable flag. Besides software writes, two hardware inputs can set or clear it. Software reaches the register with 16-bit accesses at offset 4 of the power-management window. Accesses to any other offset leave the register untouched.

Top module: `pmc_sleep_ctl`

## Requirements
- R1: A write to offset 4 stores the written word in the register with bit 13 (sleep-enable) forced to 0. A read at offset 4 therefore never shows bit 13 set.
- R2: A write to any offset other than 4 leaves the register unchanged. A read at any other offset returns 0.
- R3: Reset clears the register to zero and holds all request outputs low.
- R4: A write at offset 4 with bit 13 set and sleep type (bits 12:10) equal to 0 raises `off_req` for exactly one cycle, in the cycle after the write.
- R5: A write at offset 4 with bit 13 set and sleep type 1 raises `sus_req` for exactly one cycle, in the cycle after the write.
- R6: A write at offset 4 with bit 13 set and a sleep type of 2 or more that equals `hib_code` raises `hib_req` for one cycle in the cycle after the write. It then raises `off_req` for one cycle in the cycle after that.
- R7: A write at offset 4 with bit 13 set and a sleep type of 2 or more that differs from `hib_code` raises no request.
- R8: A write with bit 13 clear raises no request, whatever its sleep type. Sleep types 0 and 1 keep their meanings from R4 and R5 even when `hib_code` equals them.
- R9: `sci_set` sets bit 0 at the next edge, even when `sci_clr` is asserted in the same cycle.
- R10: `sci_clr` clears bit 0 at the next edge when `sci_set` is low in the same cycle.
- R11: When a software write at offset 4 coincides with `sci_set` or `sci_clr`, the hardware input decides bit 0. The other written bits are stored as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register window |
| addr | input | 4 | Byte offset inside the power-management window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data: the register at offset 4, otherwise 0 |
| hib_code | input | 3 | Sleep-type value that requests hibernate |
| sci_set | input | 1 | Hardware request to set SCI-enable |
| sci_clr | input | 1 | Hardware request to clear SCI-enable |
| sci_en | output | 1 | Current SCI-enable flag (register bit 0) |
| off_req | output | 1 | Power-off request pulse |
| sus_req | output | 1 | Suspend-to-RAM request pulse |
| hib_req | output | 1 | Hibernate request pulse |

## Verification
The decoder is driven with every class of sleep type under sleep-enable: 0, 1, a type that matches `hib_code`, and a type of 2 or more that does not match. These cases show the power-off, suspend, two-step hibernate and silent paths apart. The same types are then written with sleep-enable clear, and once with `hib_code` set to 1. These writes show that only the trigger bit fires requests and that the fixed codes win over the programmable one. A write to another offset is checked by reading the register back. The SCI flag is driven with set alone, clear alone, both together, and both against a coinciding software write, which exposes the set-over-clear and hardware-over-software orders.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_OFF  = 2'd1,
    ACT_SUS  = 2'd2,
    ACT_HIB  = 2'd3
  } pmc_act_e;

  typedef struct packed {
    logic off;
    logic sus;
    logic hib;
  } pmc_req_t;

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_type_decode.sv
module pmc_type_decode
  import pmc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SLP_BIT = 13,
  parameter int TYP_LSB = 10,
  parameter int TYP_W   = 3
) (
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TYP_W-1:0]  hib_code,
  output pmc_act_e          act
);

  localparam logic [TYP_W-1:0] TYP_OFF = TYP_W'(0);
  localparam logic [TYP_W-1:0] TYP_SUS = TYP_W'(1);

  logic             trig;
  logic [TYP_W-1:0] typ;

  always_comb begin
    trig = wr_hit & wdata[SLP_BIT];
    typ  = wdata[TYP_LSB +: TYP_W];
    act  = ACT_NONE;
    if (trig) begin
      if (typ == TYP_OFF)       act = ACT_OFF;
      else if (typ == TYP_SUS)  act = ACT_SUS;
      else if (typ == hib_code) act = ACT_HIB;
      else                      act = ACT_NONE;
    end
  end

endmodule

// File: rtl/pmc_req_seq.sv
module pmc_req_seq
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pmc_act_e act,
  output pmc_req_t req
);

  pmc_req_t req_q, req_d;
  logic     off_pend_q, off_pend_d;
  logic     upd_en;

  always_comb begin
    req_d.off  = (act == ACT_OFF) | off_pend_q;
    req_d.sus  = (act == ACT_SUS);
    req_d.hib  = (act == ACT_HIB);
    off_pend_d = (act == ACT_HIB);
    upd_en     = (act != ACT_NONE) | off_pend_q | (|req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= '0;
      off_pend_q <= 1'b0;
    end else if (upd_en) begin
      req_q      <= req_d;
      off_pend_q <= off_pend_d;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg #(
  parameter int DATA_W  = 16,
  parameter int SLP_BIT = 13,
  parameter int SCI_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sci_set,
  input  logic              sci_clr,
  output logic [DATA_W-1:0] ctrl
);

  localparam logic [DATA_W-1:0] SLP_MASK = DATA_W'(1) << SLP_BIT;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              ld_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hit) ctrl_d = wdata & ~SLP_MASK;
    if (sci_set)      ctrl_d[SCI_BIT] = 1'b1;
    else if (sci_clr) ctrl_d[SCI_BIT] = 1'b0;
    ld_en = wr_hit | sci_set | sci_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (ld_en) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/pmc_sleep_ctl.sv
module pmc_sleep_ctl
  import pmc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 4,
  parameter int SLP_BIT  = 13,
  parameter int TYP_LSB  = 10,
  parameter int TYP_W    = 3,
  parameter int SCI_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [TYP_W-1:0]  hib_code,
  input  logic              sci_set,
  input  logic              sci_clr,
  output logic              sci_en,
  output logic              off_req,
  output logic              sus_req,
  output logic              hib_req
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTRL_OFS);

  logic              rst_sync_n;
  logic              sel;
  logic              wr_hit;
  logic [DATA_W-1:0] ctrl_q;
  pmc_act_e          act;
  pmc_req_t          req;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  always_comb begin
    sel    = (addr == OFS);
    wr_hit = wr_en & sel;
    rdata  = sel ? ctrl_q : '0;
  end

  pmc_ctrl_reg #(
    .DATA_W  (DATA_W),
    .SLP_BIT (SLP_BIT),
    .SCI_BIT (SCI_BIT)
  ) u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_hit  (wr_hit),
    .wdata   (wdata),
    .sci_set (sci_set),
    .sci_clr (sci_clr),
    .ctrl    (ctrl_q)
  );

  pmc_type_decode #(
    .DATA_W  (DATA_W),
    .SLP_BIT (SLP_BIT),
    .TYP_LSB (TYP_LSB),
    .TYP_W   (TYP_W)
  ) u_dec (
    .wr_hit   (wr_hit),
    .wdata    (wdata),
    .hib_code (hib_code),
    .act      (act)
  );

  pmc_req_seq u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .act   (act),
    .req   (req)
  );

  assign sci_en  = ctrl_q[SCI_BIT];
  assign off_req = req.off;
  assign sus_req = req.sus;
  assign hib_req = req.hib;

endmodule

// File: rtl/pmc_sleep_ctl_chk.sv
module pmc_sleep_ctl_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 4,
  parameter int SLP_BIT  = 13,
  parameter int TYP_LSB  = 10,
  parameter int TYP_W    = 3,
  parameter int SCI_BIT  = 0
) (
  input logic              clk,
  input logic              srst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [TYP_W-1:0]  hib_code,
  input logic              sci_set,
  input logic              sci_clr,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              sci_en,
  input logic              off_req,
  input logic              sus_req,
  input logic              hib_req
);

  logic             hit;
  logic             trig;
  logic [TYP_W-1:0] typ;
  logic [DATA_W-1:0] slp_mask;

  always_comb begin
    hit      = wr_en && (addr == ADDR_W'(CTRL_OFS));
    trig     = hit && wdata[SLP_BIT];
    typ      = wdata[TYP_LSB +: TYP_W];
    slp_mask = DATA_W'(1) << SLP_BIT;
  end

  a_r1_store_masked: assert property (@(posedge clk) disable iff (!srst_n)
    hit && !sci_set && !sci_clr |=> ctrl_q == ($past(wdata) & ~slp_mask));

  a_r2_other_ofs_ignored: assert property (@(posedge clk) disable iff (!srst_n)
    !hit && !sci_set && !sci_clr |=> $stable(ctrl_q));

  a_r4_off_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    trig && typ == TYP_W'(0) |=> off_req && !sus_req && !hib_req);

  a_r5_sus_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    trig && typ == TYP_W'(1) |=> sus_req && !hib_req);

  a_r6_hib_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    trig && typ > TYP_W'(1) && typ == hib_code |=> hib_req && !sus_req);

  a_r6_hib_then_off: assert property (@(posedge clk) disable iff (!srst_n)
    hib_req |=> off_req);

  a_r8_no_trig_no_sus: assert property (@(posedge clk) disable iff (!srst_n)
    !trig |=> !sus_req && !hib_req);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!srst_n)
    sci_set |=> sci_en);

  a_r10_clr: assert property (@(posedge clk) disable iff (!srst_n)
    sci_clr && !sci_set |=> !sci_en);

  a_r5_single_decode: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({sus_req, hib_req}));

endmodule

bind pmc_sleep_ctl pmc_sleep_ctl_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CTRL_OFS (CTRL_OFS),
  .SLP_BIT  (SLP_BIT),
  .TYP_LSB  (TYP_LSB),
  .TYP_W    (TYP_W),
  .SCI_BIT  (SCI_BIT)
) u_chk (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .hib_code (hib_code),
  .sci_set  (sci_set),
  .sci_clr  (sci_clr),
  .ctrl_q   (ctrl_q),
  .sci_en   (sci_en),
  .off_req  (off_req),
  .sus_req  (sus_req),
  .hib_req  (hib_req)
);

// File: tb/pmc_sleep_ctl_test.sv
`timescale 1ns/1ps
module pmc_sleep_ctl_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [2:0]  hib_code;
  logic        sci_set;
  logic        sci_clr;
  logic        sci_en;
  logic        off_req;
  logic        sus_req;
  logic        hib_req;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  pmc_sleep_ctl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .hib_code (hib_code),
    .sci_set  (sci_set),
    .sci_clr  (sci_clr),
    .sci_en   (sci_en),
    .off_req  (off_req),
    .sus_req  (sus_req),
    .hib_req  (hib_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sleep_word(input bit slp, input logic [2:0] typ,
                                             input logic [15:0] other);
    logic [15:0] w;
    w = other & 16'hC3FF;
    w[12:10] = typ;
    w[13]    = slp;
    return w;
  endfunction

  // write one word; returns after sampling the cycle following the write edge
  task automatic do_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'd4; wdata = '0;
  endtask

  task automatic reqs_at_next(input logic [3:0] a, input logic [15:0] d,
                              output logic [2:0] r1, output logic [2:0] r2);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    r1 = {off_req, sus_req, hib_req};
    @(negedge clk);
    wr_en = 1'b0; addr = 4'd4; wdata = '0;
    @(posedge clk); #1;
    r2 = {off_req, sus_req, hib_req};
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R3 reg after reset", rdata, 16'h0000);
    check("R3 requests after reset", {off_req, sus_req, hib_req}, 3'b000);
    check("R3 sci_en after reset", sci_en, 1'b0);
  endtask

  task automatic t_store;
    do_write(4'd4, 16'hFFFE);
    check("R1 store masks bit13", rdata, 16'hDFFE);
    check("R1 bit13 reads 0", rdata[13], 1'b0);
    do_write(4'd4, 16'h0000);
  endtask

  task automatic t_other_ofs;
    do_write(4'd4, 16'h0402);
    do_write(4'd0, 16'h5555);
    do_write(4'd6, 16'h2000);
    @(negedge clk);
    check("R2 reg kept after off-window write", rdata, 16'h0402);
    check("R2 no request from off-window write", {off_req, sus_req, hib_req}, 3'b000);
    addr = 4'd8; #0.5;
    check("R2 read elsewhere is 0", rdata, 16'h0000);
    addr = 4'd4;
    do_write(4'd4, 16'h0000);
  endtask

  task automatic t_type0;
    logic [2:0] r1, r2;
    reqs_at_next(4'd4, sleep_word(1'b1, 3'd0, 16'h0000), r1, r2);
    check("R4 off pulse", r1, 3'b100);
    check("R4 off pulse one cycle", r2, 3'b000);
  endtask

  task automatic t_type1;
    logic [2:0] r1, r2;
    reqs_at_next(4'd4, sleep_word(1'b1, 3'd1, 16'h0000), r1, r2);
    check("R5 sus pulse", r1, 3'b010);
    check("R5 sus pulse one cycle", r2, 3'b000);
  endtask

  task automatic t_hib;
    logic [2:0] r1, r2;
    hib_code = 3'd5;
    reqs_at_next(4'd4, sleep_word(1'b1, 3'd5, 16'h0000), r1, r2);
    check("R6 hib first", r1, 3'b001);
    check("R6 off follows hib", r2, 3'b100);
    @(posedge clk); #1;
    check("R6 off one cycle", {off_req, sus_req, hib_req}, 3'b000);
  endtask

  task automatic t_other_type;
    logic [2:0] r1, r2;
    hib_code = 3'd5;
    for (int t = 2; t < 8; t++) begin
      if (t != 5) begin
        reqs_at_next(4'd4, sleep_word(1'b1, 3'(t), 16'h0000), r1, r2);
        check("R7 unmatched type silent", {r1, r2}, 6'b000000);
      end
    end
  endtask

  task automatic t_no_slp;
    logic [2:0] r1, r2;
    for (int t = 0; t < 8; t++) begin
      reqs_at_next(4'd4, sleep_word(1'b0, 3'(t), 16'h0000), r1, r2);
      check("R8 no trigger silent", {r1, r2}, 6'b000000);
    end
    hib_code = 3'd1;
    reqs_at_next(4'd4, sleep_word(1'b1, 3'd1, 16'h0000), r1, r2);
    check("R8 type1 stays suspend", {r1, r2}, 6'b010000);
    hib_code = 3'd5;
  endtask

  task automatic t_sci;
    @(negedge clk); sci_set = 1'b1;
    @(negedge clk); sci_set = 1'b0;
    check("R9 set", sci_en, 1'b1);
    @(negedge clk); sci_clr = 1'b1;
    @(negedge clk); sci_clr = 1'b0;
    check("R10 clear", sci_en, 1'b0);
    @(negedge clk); sci_set = 1'b1; sci_clr = 1'b1;
    @(negedge clk); sci_set = 1'b0; sci_clr = 1'b0;
    check("R9 set beats clear", sci_en, 1'b1);
  endtask

  task automatic t_sci_override;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd4; wdata = 16'h0100; sci_set = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sci_set = 1'b0; wdata = '0;
    check("R11 set over write", rdata, 16'h0101);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd4; wdata = 16'h0081; sci_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sci_clr = 1'b0; wdata = '0;
    check("R11 clear over write", rdata, 16'h0080);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 4'd4; wdata = '0;
    hib_code = 3'd5; sci_set = 1'b0; sci_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_store();
    t_other_ofs();
    t_type0();
    t_type1();
    t_hib();
    t_other_type();
    t_no_slp();
    t_sci();
    t_sci_override();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule